// File: doc/BRIEF.md
# Command-Driven Event Sequencer

The block replays a list of commands that a host has loaded into a FIFO as timed address-events, so that the host can act as an extra sender chip on one input channel of an address-event arbiter. Each FIFO word is 18 bits wide and has an opcode and an operand. A command can emit one event, pause for a number of time-base ticks, hold until a free-running 32-bit time counter reaches a target, or stop the sequence.

The FIFO is a first-word-fall-through store. While `fifo_empty_i` is low, the word at its head is present on `fifo_data_i`, and a high `fifo_rd_o` during a clock cycle removes that word. A 2-bit select names the arbiter channel that the sequencer drives. While the sequencer is enabled, that channel is cut off from its external sender. All other channels, and every channel while the sequencer is disabled, pass straight through. A one-cycle drain pulse marks each time the FIFO runs dry while the sequencer is enabled.

Top module: `evt_seq`

## Requirements
- R1: Bits 17:16 of a FIFO word hold the opcode and bits 15:0 hold the operand. Opcode 01 emits one event on the selected channel, with the operand as its 16-bit label. Events appear in FIFO order.
- R2: A request stays high until the acknowledge of the selected channel is high. The request then drops. No further word is read until that acknowledge has returned low.
- R3: Opcode 10 pauses for as many cycles with `tick_i` high as the operand says, and cycles with `tick_i` low do not count. An operand of 0 lets the next command run without waiting for any tick.
- R4: Opcode 11 spans two words. The operand of the first word is bits 31:16 of the target time and the operand of the second word is bits 15:0. With `ge_mode_i` low, execution resumes only when `time_i` equals the target, so a target that has already passed waits for the counter to wrap.
- R5: With `ge_mode_i` high, an absolute wait resumes as soon as `time_i` is greater than or equal to the target.
- R6: `fifo_rd_o` is never high while `fifo_empty_i` is high. The sequencer stalls while the FIFO is empty.
- R7: Opcode 00 ends the sequence. No further word is read and no event is emitted until `en_i` goes low and then high again.
- R8: While `en_i` is high, channel `chan_sel_i` of `arb_req_o`/`arb_label_o` carries the sequencer. On that channel, `ext_req_i` is ignored and `ext_ack_o` is 0. Every other channel, and every channel while `en_i` is low, connects `ext_*` to `arb_*` directly.
- R9: `drain_o` pulses high for one cycle, one clock after `fifo_empty_i` goes from low to high while `en_i` is high.
- R10: After reset, or while `en_i` is low, the sequencer issues no request and no FIFO read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Sequencer enable; a rising edge restarts it after an end command |
| ge_mode_i | input | 1 | Absolute wait resumes on greater-or-equal instead of equality |
| chan_sel_i | input | 2 | Arbiter channel taken over by the sequencer |
| fifo_empty_i | input | 1 | Command FIFO empty |
| fifo_data_i | input | 18 | Head word of the command FIFO |
| fifo_rd_o | output | 1 | Pop the head word |
| tick_i | input | 1 | Time-base tick enable |
| time_i | input | 32 | Absolute time counter |
| ext_req_i | input | 4 | Requests from the external senders |
| ext_label_i | input | 64 | Labels from the external senders, 16 bits per channel |
| ext_ack_o | output | 4 | Acknowledges to the external senders |
| arb_req_o | output | 4 | Requests to the arbiter inputs |
| arb_label_o | output | 64 | Labels to the arbiter inputs, 16 bits per channel |
| arb_ack_i | input | 4 | Acknowledges from the arbiter inputs |
| drain_o | output | 1 | One-cycle pulse when the FIFO drains |

## Verification
Some rules are checked by assertions on every cycle. These cover the request hold until acknowledge, the request dropping only after an acknowledge, the delay counter staying frozen on cycles without a tick, an equality wait never leaving early, and the absence of reads after an end command. Other behaviour can only be shown by the bench's scenarios, because each involves a whole command list over time. These are the label order of emitted events, the exact number of ticks a delay consumes, the order of the two halves of a time target, the wrap versus greater-or-equal choice, the restart after an end command, the channel takeover and the drain pulse.

// File: rtl/evt_seq_pkg.sv
package evt_seq_pkg;
  typedef enum logic [1:0] {
    OP_END   = 2'b00,
    OP_EMIT  = 2'b01,
    OP_DELAY = 2'b10,
    OP_ABS   = 2'b11
  } op_e;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_REQ, S_REL, S_DELAY, S_ABS_LO, S_ABS_WAIT, S_DONE
  } st_e;
endpackage

// File: rtl/evt_seq_ctrl.sv
module evt_seq_ctrl
  import evt_seq_pkg::*;
#(
  parameter int LBL_W  = 16,
  parameter int TIME_W = 32,
  localparam int OP_W   = 2,
  localparam int WORD_W = OP_W + LBL_W,
  localparam int HI_W   = TIME_W - LBL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              ge_mode_i,
  input  logic              fifo_empty_i,
  input  logic [WORD_W-1:0] fifo_data_i,
  output logic              fifo_rd_o,
  input  logic              tick_i,
  input  logic [TIME_W-1:0] time_i,
  output logic              req_o,
  input  logic              ack_i,
  output logic [LBL_W-1:0]  label_o
);
  st_e st_q, st_d;
  logic [LBL_W-1:0]  cnt_q, cnt_d, lbl_q, lbl_d;
  logic [HI_W-1:0]   hi_q, hi_d;
  logic [TIME_W-1:0] tgt_q, tgt_d;
  op_e               op;
  logic [LBL_W-1:0]  arg;
  logic              take, hit;

  assign op   = op_e'(fifo_data_i[WORD_W-1 -: OP_W]);
  assign arg  = fifo_data_i[LBL_W-1:0];
  assign take = en_i && !fifo_empty_i && (st_q == S_FETCH || st_q == S_ABS_LO);
  assign hit  = ge_mode_i ? (time_i >= tgt_q) : (time_i == tgt_q);

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    lbl_d = lbl_q;
    hi_d  = hi_q;
    tgt_d = tgt_q;
    if (!en_i) begin
      st_d = S_IDLE;
    end else begin
      case (st_q)
        S_IDLE: st_d = S_FETCH;
        S_FETCH: if (take) begin
          case (op)
            OP_EMIT: begin
              lbl_d = arg;
              st_d  = S_REQ;
            end
            OP_DELAY: begin
              cnt_d = arg;
              st_d  = (arg == '0) ? S_FETCH : S_DELAY;
            end
            OP_ABS: begin
              hi_d = arg[HI_W-1:0];
              st_d = S_ABS_LO;
            end
            default: st_d = S_DONE;
          endcase
        end
        S_REQ: if (ack_i) st_d = S_REL;
        S_REL: if (!ack_i) st_d = S_FETCH;
        S_DELAY: if (tick_i) begin
          cnt_d = cnt_q - LBL_W'(1);
          if (cnt_q == LBL_W'(1)) st_d = S_FETCH;
        end
        S_ABS_LO: if (take) begin
          tgt_d = {hi_q, arg};
          st_d  = S_ABS_WAIT;
        end
        S_ABS_WAIT: if (hit) st_d = S_FETCH;
        default: st_d = S_DONE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= S_IDLE;
      cnt_q <= '0;
      lbl_q <= '0;
      hi_q  <= '0;
      tgt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      lbl_q <= lbl_d;
      hi_q  <= hi_d;
      tgt_q <= tgt_d;
    end
  end

  assign fifo_rd_o = take;
  assign req_o     = (st_q == S_REQ);
  assign label_o   = lbl_q;

  assert_hold_req_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && !ack_i && en_i |=> req_o || !en_i);

  assert_drop_after_ack_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(req_o) |-> $past(ack_i) || !$past(en_i));

  assert_delay_frozen_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == S_DELAY && !tick_i && en_i |=> st_q == S_DELAY && $stable(cnt_q));

  assert_exact_wait_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == S_ABS_WAIT && en_i && !ge_mode_i && time_i != tgt_q |=> st_q == S_ABS_WAIT || !en_i);

  assert_end_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == S_DONE && en_i |=> !fifo_rd_o && !req_o);
endmodule

// File: rtl/evt_seq_chan_mux.sv
module evt_seq_chan_mux #(
  parameter int N_CH  = 4,
  parameter int LBL_W = 16,
  localparam int CH_W = $clog2(N_CH)
) (
  input  logic                  en_i,
  input  logic [CH_W-1:0]       sel_i,
  input  logic                  seq_req_i,
  input  logic [LBL_W-1:0]      seq_label_i,
  output logic                  seq_ack_o,
  input  logic [N_CH-1:0]       ext_req_i,
  input  logic [N_CH*LBL_W-1:0] ext_label_i,
  output logic [N_CH-1:0]       ext_ack_o,
  output logic [N_CH-1:0]       arb_req_o,
  output logic [N_CH*LBL_W-1:0] arb_label_o,
  input  logic [N_CH-1:0]       arb_ack_i
);
  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic own;
    assign own = en_i && (sel_i == CH_W'(c));
    assign arb_req_o[c]                  = own ? seq_req_i : ext_req_i[c];
    assign arb_label_o[c*LBL_W +: LBL_W] = own ? seq_label_i : ext_label_i[c*LBL_W +: LBL_W];
    assign ext_ack_o[c]                  = own ? 1'b0 : arb_ack_i[c];
  end

  assign seq_ack_o = arb_ack_i[sel_i];
endmodule

// File: rtl/evt_seq_drain.sv
module evt_seq_drain (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic fifo_empty_i,
  output logic drain_o
);
  logic prev_q, drain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= 1'b1;
      drain_q <= 1'b0;
    end else begin
      prev_q  <= fifo_empty_i;
      drain_q <= en_i && fifo_empty_i && !prev_q;
    end
  end

  assign drain_o = drain_q;
endmodule

// File: rtl/evt_seq.sv
module evt_seq #(
  parameter int N_CH   = 4,
  parameter int LBL_W  = 16,
  parameter int TIME_W = 32,
  localparam int CH_W   = $clog2(N_CH),
  localparam int WORD_W = LBL_W + 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  en_i,
  input  logic                  ge_mode_i,
  input  logic [CH_W-1:0]       chan_sel_i,
  input  logic                  fifo_empty_i,
  input  logic [WORD_W-1:0]     fifo_data_i,
  output logic                  fifo_rd_o,
  input  logic                  tick_i,
  input  logic [TIME_W-1:0]     time_i,
  input  logic [N_CH-1:0]       ext_req_i,
  input  logic [N_CH*LBL_W-1:0] ext_label_i,
  output logic [N_CH-1:0]       ext_ack_o,
  output logic [N_CH-1:0]       arb_req_o,
  output logic [N_CH*LBL_W-1:0] arb_label_o,
  input  logic [N_CH-1:0]       arb_ack_i,
  output logic                  drain_o
);
  logic             seq_req, seq_ack;
  logic [LBL_W-1:0] seq_label;

  evt_seq_ctrl #(.LBL_W(LBL_W), .TIME_W(TIME_W)) u_ctrl (
    .clk_i, .rst_ni, .en_i, .ge_mode_i, .fifo_empty_i, .fifo_data_i, .fifo_rd_o,
    .tick_i, .time_i, .req_o(seq_req), .ack_i(seq_ack), .label_o(seq_label)
  );

  evt_seq_chan_mux #(.N_CH(N_CH), .LBL_W(LBL_W)) u_mux (
    .en_i, .sel_i(chan_sel_i), .seq_req_i(seq_req), .seq_label_i(seq_label),
    .seq_ack_o(seq_ack), .ext_req_i, .ext_label_i, .ext_ack_o, .arb_req_o,
    .arb_label_o, .arb_ack_i
  );

  evt_seq_drain u_drain (
    .clk_i, .rst_ni, .en_i, .fifo_empty_i, .drain_o
  );
endmodule

// File: tb/sim_evt_seq.sv
module sim_evt_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0, ge = 1'b0, tick = 1'b0;
  logic [1:0]  sel = 2'd2;
  logic        fifo_empty = 1'b1;
  logic [17:0] fifo_data = '0;
  logic        fifo_rd;
  logic [31:0] tme = '0;
  logic [3:0]  ext_req = '0, ext_ack, arb_req, arb_ack = '0;
  logic [63:0] ext_label = '0, arb_label;
  logic        drain;

  always #2 clk = ~clk;

  evt_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .ge_mode_i(ge), .chan_sel_i(sel),
    .fifo_empty_i(fifo_empty), .fifo_data_i(fifo_data), .fifo_rd_o(fifo_rd),
    .tick_i(tick), .time_i(tme), .ext_req_i(ext_req), .ext_label_i(ext_label),
    .ext_ack_o(ext_ack), .arb_req_o(arb_req), .arb_label_o(arb_label),
    .arb_ack_i(arb_ack), .drain_o(drain)
  );

  int n_chk = 0, n_bad = 0, evt_cnt = 0, drain_cnt = 0, bad_rd = 0, cyc = 0;
  logic [17:0] fq[$];
  logic [15:0] exp_q[$];
  logic pop_pend = 1'b0, prev_req = 1'b0, auto_ack = 1'b1, done = 1'b0;

  task automatic chk(input bit ok, input string r, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", r, act, exp);
    end
  endtask

  task automatic push(input logic [1:0] op, input logic [15:0] arg);
    fq.push_back({op, arg});
    fifo_empty = 1'b0;
    fifo_data  = fq[0];
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_tick();
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  // FIFO model: pop at the negedge after a read at posedge
  always @(posedge clk) begin
    pop_pend <= fifo_rd;
    if (fifo_rd && fifo_empty) bad_rd++;
    cyc++;
  end

  always @(negedge clk) begin
    if (pop_pend && fq.size() > 0) void'(fq.pop_front());
    fifo_empty = (fq.size() == 0);
    fifo_data  = (fq.size() > 0) ? fq[0] : '0;
    if (auto_ack) arb_ack = arb_req;
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (drain) drain_cnt++;
    if (en && arb_req[sel] && !prev_req) begin
      evt_cnt++;
      if (exp_q.size() == 0) chk(1'b0, "R1 unexpected event", 64'(arb_label[sel*16 +: 16]), 0);
      else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        chk(arb_label[sel*16 +: 16] == e, "R1 label", 64'(arb_label[sel*16 +: 16]), 64'(e));
      end
    end
    prev_req = en && arb_req[sel];
  end

  always @(posedge clk) if (cyc > 100000 && !done) begin
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d expected <100000", cyc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int e0, d0;
    ext_label = {16'hA003, 16'hA002, 16'hA001, 16'hA000};
    wait_n(4);
    // R10 reset state
    chk(fifo_rd == 0, "R10 no read", 64'(fifo_rd), 0);
    chk(arb_req == 0 && drain == 0, "R10 no request", 64'(arb_req), 0);
    rst_n = 1'b1;
    wait_n(2);
    // R8 disabled: all channels pass through
    ext_req = 4'b1010;
    wait_n(3);
    chk(arb_req == 4'b1010, "R8 pass req", 64'(arb_req), 64'hA);
    chk(arb_label == ext_label, "R8 pass label", arb_label, ext_label);
    chk(ext_ack == 4'b1010, "R8 pass ack", 64'(ext_ack), 64'hA);
    // R8 enabled: channel 2 taken over
    ext_req = 4'b0110;
    en = 1'b1;
    wait_n(3);
    chk(arb_req == 4'b0010, "R8 takeover req", 64'(arb_req), 64'h2);
    chk(ext_ack == 4'b0010, "R8 takeover ack", 64'(ext_ack), 64'h2);
    chk(fifo_rd == 0, "R6 stall on empty", 64'(fifo_rd), 0);
    ext_req = '0;
    wait_n(3);
    // R1 plain events
    e0 = evt_cnt;
    exp_q.push_back(16'h26FE); exp_q.push_back(16'hF433); exp_q.push_back(16'h3344);
    push(2'b01, 16'h26FE); push(2'b01, 16'hF433); push(2'b01, 16'h3344);
    wait_n(30);
    chk(evt_cnt - e0 == 3, "R1 event count", 64'(evt_cnt - e0), 3);
    // R2 handshake
    auto_ack = 1'b0; arb_ack = '0;
    exp_q.push_back(16'h1111);
    push(2'b01, 16'h1111);
    wait_n(10);
    chk(arb_req[2] == 1, "R2 req held", 64'(arb_req[2]), 1);
    arb_ack[2] = 1'b1;
    wait_n(3);
    chk(arb_req[2] == 0, "R2 req released", 64'(arb_req[2]), 0);
    exp_q.push_back(16'h2222);
    push(2'b01, 16'h2222);
    wait_n(10);
    chk(arb_req[2] == 0, "R2 no req while ack high", 64'(arb_req[2]), 0);
    chk(fq.size() == 1, "R2 no fetch while ack high", 64'(fq.size()), 1);
    arb_ack[2] = 1'b0; auto_ack = 1'b1;
    wait_n(10);
    chk(exp_q.size() == 0, "R2 resumes", 64'(exp_q.size()), 0);
    // R3 relative delay
    e0 = evt_cnt;
    exp_q.push_back(16'h00A1); exp_q.push_back(16'h00B2);
    push(2'b01, 16'h00A1); push(2'b10, 16'h0003); push(2'b01, 16'h00B2);
    wait_n(20);
    chk(evt_cnt - e0 == 1, "R3 waits for ticks", 64'(evt_cnt - e0), 1);
    pulse_tick(); wait_n(3); pulse_tick();
    wait_n(10);
    chk(evt_cnt - e0 == 1, "R3 two of three ticks", 64'(evt_cnt - e0), 1);
    pulse_tick();
    wait_n(10);
    chk(evt_cnt - e0 == 2, "R3 third tick", 64'(evt_cnt - e0), 2);
    e0 = evt_cnt;
    exp_q.push_back(16'h00C3); exp_q.push_back(16'h00D4);
    push(2'b01, 16'h00C3); push(2'b10, 16'h0000); push(2'b01, 16'h00D4);
    wait_n(20);
    chk(evt_cnt - e0 == 2, "R3 zero delay", 64'(evt_cnt - e0), 2);
    // R4 absolute wait, equality
    e0 = evt_cnt; tme = 32'd100;
    exp_q.push_back(16'h0E01);
    push(2'b11, 16'h0000); push(2'b11, 16'h00C8); push(2'b01, 16'h0E01);
    wait_n(20);
    chk(evt_cnt == e0, "R4 before target", 64'(evt_cnt - e0), 0);
    tme = 32'd199; wait_n(5);
    chk(evt_cnt == e0, "R4 one short", 64'(evt_cnt - e0), 0);
    tme = 32'd200; wait_n(10);
    chk(evt_cnt - e0 == 1, "R4 at target", 64'(evt_cnt - e0), 1);
    // R4 high half comes first
    e0 = evt_cnt; tme = 32'h0000_0001;
    exp_q.push_back(16'h0E02);
    push(2'b11, 16'h0001); push(2'b11, 16'h0000); push(2'b01, 16'h0E02);
    wait_n(20);
    chk(evt_cnt == e0, "R4 high half", 64'(evt_cnt - e0), 0);
    tme = 32'h0001_0000; wait_n(10);
    chk(evt_cnt - e0 == 1, "R4 high half hit", 64'(evt_cnt - e0), 1);
    // R4 past target waits for wrap
    e0 = evt_cnt; tme = 32'd500;
    exp_q.push_back(16'h0E03);
    push(2'b11, 16'h0000); push(2'b11, 16'd300); push(2'b01, 16'h0E03);
    wait_n(20);
    chk(evt_cnt == e0, "R4 past target", 64'(evt_cnt - e0), 0);
    tme = 32'd300; wait_n(10);
    chk(evt_cnt - e0 == 1, "R4 after wrap", 64'(evt_cnt - e0), 1);
    // R5 greater-or-equal
    e0 = evt_cnt; ge = 1'b1; tme = 32'd500;
    exp_q.push_back(16'h0E04);
    push(2'b11, 16'h0000); push(2'b11, 16'd300); push(2'b01, 16'h0E04);
    wait_n(20);
    chk(evt_cnt - e0 == 1, "R5 past target resumes", 64'(evt_cnt - e0), 1);
    ge = 1'b0;
    // R7 end command
    e0 = evt_cnt;
    exp_q.push_back(16'h0F0F);
    push(2'b00, 16'h0000); push(2'b01, 16'h0F0F);
    wait_n(20);
    chk(evt_cnt == e0, "R7 no event after end", 64'(evt_cnt - e0), 0);
    chk(fq.size() == 1, "R7 no read after end", 64'(fq.size()), 1);
    en = 1'b0; wait_n(3);
    chk(arb_req == 0 && fifo_rd == 0, "R10 disabled quiet", 64'(arb_req), 0);
    en = 1'b1; wait_n(20);
    chk(evt_cnt - e0 == 1, "R7 restart", 64'(evt_cnt - e0), 1);
    // R9 drain pulse
    wait_n(5);
    d0 = drain_cnt;
    exp_q.push_back(16'h5A5A); exp_q.push_back(16'hA5A5);
    push(2'b01, 16'h5A5A); push(2'b01, 16'hA5A5);
    wait_n(20);
    chk(drain_cnt - d0 == 1, "R9 one drain pulse", 64'(drain_cnt - d0), 1);
    chk(exp_q.size() == 0, "R1 all events seen", 64'(exp_q.size()), 0);
    chk(bad_rd == 0, "R6 read while empty", 64'(bad_rd), 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule